// File: doc/BRIEF.md
# Guest Trap-Vector CSR Unit

This unit holds the trap-vector register that belongs to a virtualized guest running in supervisor mode, inside a processor that supports a hypervisor. It decodes CSR accesses, routes them by the virtualization flag and the current privilege, and legalizes every write before it is stored. A guest that uses the ordinary supervisor trap-vector address reaches this guest copy. A guest that uses the dedicated guest address gets a virtual-instruction fault.

A second, purely combinational port computes the next program counter when a trap enters the guest. The stored word has two fields. The upper bits, from XLEN-1 down to 2, hold a base that is always 4-byte aligned. The low two bits hold a mode. In direct mode every trap goes to the base. In vectored mode an interrupt is sent to an offset from the base that scales with its cause.

CSR responses are combinational in the cycle of the request. A write changes the stored value at the next rising clock edge.

Top module: `gtvec_csr_unit`

## Requirements
- R1: After reset the stored value is zero, which is base 0 in direct mode. A read returns 0 and the trap target is 0.
- R2: With the virtualization flag at 0 and privilege supervisor (1) or machine (3), a request to address 0x205 asserts the guest-hit flag. It reads the stored value and applies the write operation.
- R3: With the virtualization flag at 0 and privilege user (0), a request to 0x205 asserts the illegal-instruction flag and leaves the stored value unchanged.
- R4: With the virtualization flag at 1, a request to 0x205 at any privilege asserts the virtual-instruction flag and leaves the stored value unchanged.
- R5: With the virtualization flag at 1 and privilege other than user, a request to 0x105 asserts the guest-hit flag. It reads and writes the guest copy.
- R6: With the virtualization flag at 0, a request to 0x105 asserts only the host flag. Read data is 0 and the guest copy is unchanged.
- R7: The operation code is 0 for read, 1 for write, 2 for set bits and 3 for clear bits. Set ORs the write data into the current value, and clear removes the write-data bits from it. Both happen before legalization.
- R8: The mode field is bits 1:0. If a write would leave that field at 2 or 3, the previous mode is kept while the base bits still take the new value. The stored mode is never 2 or 3.
- R9: In direct mode (0) the trap target is the base for both interrupts and synchronous exceptions.
- R10: In vectored mode (1) a synchronous exception targets the base, and an interrupt targets base + 4 × cause.
- R11: With the virtualization flag at 1 and privilege user, a request to 0x105 asserts the virtual-instruction flag and leaves the stored value unchanged.
- R12: At most one of the four response flags is set. Read data is 0 whenever the guest-hit flag is low. A request to any other address, or no request, sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_req_i | input | 1 | CSR access valid this cycle |
| csr_addr_i | input | 12 | CSR address |
| csr_op_i | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| csr_wdata_i | input | XLEN | Write operand |
| csr_priv_i | input | 2 | 0 user, 1 supervisor, 3 machine |
| csr_virt_i | input | 1 | Virtualization flag |
| csr_rdata_o | output | XLEN | Read data, valid with the guest-hit flag |
| csr_guest_o | output | 1 | Access reached the guest copy |
| csr_host_o | output | 1 | Access belongs to the host supervisor register |
| csr_illegal_o | output | 1 | Illegal-instruction exception |
| csr_vfault_o | output | 1 | Virtual-instruction exception |
| trap_irq_i | input | 1 | Trap being entered is an interrupt |
| trap_cause_i | input | CAUSE_W | Trap cause number |
| trap_pc_o | output | XLEN | Next program counter for a guest trap |

## Verification
The bench targets the routing table: both addresses under both flag values and every privilege. A design with the alias inverted would let a guest corrupt host state through 0x105, or let it write the register directly through 0x205. Writes that carry reserved mode values are checked to keep the old mode and still update the base; a plain masking design would store mode 2 or drop the base. Set and clear are checked against the prior value, and a design that legalized before combining would get the mode bits wrong. Vectored targets are checked at cause 0, at the largest cause and for exceptions, which catches a missing shift by two or a vectored offset applied to exceptions.

// File: rtl/gtvec_pkg.sv
package gtvec_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_SET   = 2'd2,
        OP_CLEAR = 2'd3
    } csr_op_e;

    typedef enum logic [1:0] {
        MODE_DIRECT = 2'd0,
        MODE_VECTOR = 2'd1,
        MODE_RSVD2  = 2'd2,
        MODE_RSVD3  = 2'd3
    } vec_mode_e;

    localparam logic [1:0]  PRIV_USER  = 2'd0;
    localparam logic [11:0] ADDR_GUEST = 12'h205;
    localparam logic [11:0] ADDR_SUPER = 12'h105;

    typedef struct packed {
        logic guest;
        logic host;
        logic illegal;
        logic vfault;
    } route_t;

endpackage

// File: rtl/gtvec_route.sv
module gtvec_route
    import gtvec_pkg::*;
(
    input  logic        req_i,
    input  logic [11:0] addr_i,
    input  logic [1:0]  priv_i,
    input  logic        virt_i,
    output route_t      route_o
);
    logic is_guest_addr;
    logic is_super_addr;
    logic from_user;

    always_comb begin
        is_guest_addr = req_i && (addr_i == ADDR_GUEST);
        is_super_addr = req_i && (addr_i == ADDR_SUPER);
        from_user     = (priv_i == PRIV_USER);
        route_o       = '0;
        if (is_guest_addr) begin
            if (virt_i)         route_o.vfault  = 1'b1;
            else if (from_user) route_o.illegal = 1'b1;
            else                route_o.guest   = 1'b1;
        end else if (is_super_addr) begin
            if (!virt_i)        route_o.host    = 1'b1;
            else if (from_user) route_o.vfault  = 1'b1;
            else                route_o.guest   = 1'b1;
        end
    end
endmodule

// File: rtl/gtvec_legalize.sv
module gtvec_legalize
    import gtvec_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [1:0]      op_i,
    input  logic [XLEN-1:0] cur_i,
    input  logic [XLEN-1:0] wdata_i,
    output logic [XLEN-1:0] next_o
);
    logic [XLEN-1:0] merged;
    vec_mode_e       req_mode;

    always_comb begin
        unique case (csr_op_e'(op_i))
            OP_WRITE: merged = wdata_i;
            OP_SET:   merged = cur_i | wdata_i;
            OP_CLEAR: merged = cur_i & ~wdata_i;
            default:  merged = cur_i;
        endcase
        req_mode = vec_mode_e'(merged[1:0]);
        next_o   = merged;
        if (req_mode == MODE_RSVD2 || req_mode == MODE_RSVD3) begin
            next_o[1:0] = cur_i[1:0];
        end
    end
endmodule

// File: rtl/gtvec_target.sv
module gtvec_target
    import gtvec_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int CAUSE_W = 6
) (
    input  logic [XLEN-1:0]    vec_i,
    input  logic               irq_i,
    input  logic [CAUSE_W-1:0] cause_i,
    output logic [XLEN-1:0]    pc_o
);
    localparam int OFF_W = CAUSE_W + 2;

    logic [XLEN-1:0]  base;
    logic [OFF_W-1:0] offset;

    always_comb begin
        base   = {vec_i[XLEN-1:2], 2'b00};
        offset = {cause_i, 2'b00};
        if (irq_i && vec_mode_e'(vec_i[1:0]) == MODE_VECTOR) begin
            pc_o = base + XLEN'(offset);
        end else begin
            pc_o = base;
        end
    end
endmodule

// File: rtl/gtvec_csr_unit.sv
module gtvec_csr_unit
    import gtvec_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter int CAUSE_W = 6
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               csr_req_i,
    input  logic [11:0]        csr_addr_i,
    input  logic [1:0]         csr_op_i,
    input  logic [XLEN-1:0]    csr_wdata_i,
    input  logic [1:0]         csr_priv_i,
    input  logic               csr_virt_i,
    output logic [XLEN-1:0]    csr_rdata_o,
    output logic               csr_guest_o,
    output logic               csr_host_o,
    output logic               csr_illegal_o,
    output logic               csr_vfault_o,
    input  logic               trap_irq_i,
    input  logic [CAUSE_W-1:0] trap_cause_i,
    output logic [XLEN-1:0]    trap_pc_o
);
    typedef struct packed {
        logic [XLEN-1:0] vec;
    } state_t;

    state_t          state_d, state_q;
    route_t          route;
    logic [XLEN-1:0] legal_vec;
    logic [XLEN-1:0] vec_cur;

    assign vec_cur = state_q.vec;

    gtvec_route u_route (
        .req_i   (csr_req_i),
        .addr_i  (csr_addr_i),
        .priv_i  (csr_priv_i),
        .virt_i  (csr_virt_i),
        .route_o (route)
    );

    gtvec_legalize #(.XLEN(XLEN)) u_legal (
        .op_i    (csr_op_i),
        .cur_i   (state_q.vec),
        .wdata_i (csr_wdata_i),
        .next_o  (legal_vec)
    );

    gtvec_target #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_target (
        .vec_i   (state_q.vec),
        .irq_i   (trap_irq_i),
        .cause_i (trap_cause_i),
        .pc_o    (trap_pc_o)
    );

    always_comb begin
        state_d = state_q;
        if (route.guest && csr_op_e'(csr_op_i) != OP_READ) begin
            state_d.vec = legal_vec;
        end
        csr_rdata_o   = route.guest ? state_q.vec : '0;
        csr_guest_o   = route.guest;
        csr_host_o    = route.host;
        csr_illegal_o = route.illegal;
        csr_vfault_o  = route.vfault;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/gtvec_csr_checker.sv
module gtvec_csr_checker #(
    parameter int XLEN = 64
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            csr_req_i,
    input logic [XLEN-1:0] csr_rdata_o,
    input logic            csr_guest_o,
    input logic            csr_host_o,
    input logic            csr_illegal_o,
    input logic            csr_vfault_o,
    input logic            trap_irq_i,
    input logic [XLEN-1:0] trap_pc_o,
    input logic [XLEN-1:0] vec_q
);
    a_r3_illegal_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_req_i && csr_illegal_o) |=> $stable(vec_q));

    a_r4_vfault_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_req_i && csr_vfault_o) |=> $stable(vec_q));

    a_r6_host_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        csr_host_o |=> $stable(vec_q));

    a_r8_mode_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vec_q[1] == 1'b0);

    a_r9_direct_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_q[1:0] == 2'd0) |-> trap_pc_o == {vec_q[XLEN-1:2], 2'b00});

    a_r10_exc_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trap_irq_i |-> trap_pc_o == {vec_q[XLEN-1:2], 2'b00});

    a_r12_one_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({csr_guest_o, csr_host_o, csr_illegal_o, csr_vfault_o}) <= 1);

    a_r12_quiet_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !csr_req_i |-> !(csr_guest_o || csr_host_o || csr_illegal_o || csr_vfault_o));

    a_r12_rdata_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !csr_guest_o |-> csr_rdata_o == '0);
endmodule

bind gtvec_csr_unit gtvec_csr_checker #(.XLEN(XLEN)) u_checker (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .csr_req_i     (csr_req_i),
    .csr_rdata_o   (csr_rdata_o),
    .csr_guest_o   (csr_guest_o),
    .csr_host_o    (csr_host_o),
    .csr_illegal_o (csr_illegal_o),
    .csr_vfault_o  (csr_vfault_o),
    .trap_irq_i    (trap_irq_i),
    .trap_pc_o     (trap_pc_o),
    .vec_q         (vec_cur)
);

// File: tb/tb_gtvec_csr_unit.sv
module tb_gtvec_csr_unit;
    localparam int XLEN    = 64;
    localparam int CAUSE_W = 6;

    logic               clk = 1'b0;
    logic               rst_ni = 1'b0;
    logic               csr_req_i = 1'b0;
    logic [11:0]        csr_addr_i = '0;
    logic [1:0]         csr_op_i = '0;
    logic [XLEN-1:0]    csr_wdata_i = '0;
    logic [1:0]         csr_priv_i = '0;
    logic               csr_virt_i = 1'b0;
    logic [XLEN-1:0]    csr_rdata_o;
    logic               csr_guest_o, csr_host_o, csr_illegal_o, csr_vfault_o;
    logic               trap_irq_i = 1'b0;
    logic [CAUSE_W-1:0] trap_cause_i = '0;
    logic [XLEN-1:0]    trap_pc_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [XLEN-1:0] model = '0;

    always #2 clk = ~clk;

    gtvec_csr_unit #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) dut (
        .clk_i(clk), .rst_ni(rst_ni),
        .csr_req_i(csr_req_i), .csr_addr_i(csr_addr_i), .csr_op_i(csr_op_i),
        .csr_wdata_i(csr_wdata_i), .csr_priv_i(csr_priv_i), .csr_virt_i(csr_virt_i),
        .csr_rdata_o(csr_rdata_o), .csr_guest_o(csr_guest_o), .csr_host_o(csr_host_o),
        .csr_illegal_o(csr_illegal_o), .csr_vfault_o(csr_vfault_o),
        .trap_irq_i(trap_irq_i), .trap_cause_i(trap_cause_i), .trap_pc_o(trap_pc_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // kinds: 0 none, 1 guest, 2 host, 3 illegal, 4 virtual fault
    function automatic int route_of(input logic req, input logic [11:0] a,
                                    input logic [1:0] p, input logic v);
        if (!req) return 0;
        if (a == 12'h205) begin
            if (v) return 4;
            if (p == 2'd0) return 3;
            return 1;
        end
        if (a == 12'h105) begin
            if (!v) return 2;
            if (p == 2'd0) return 4;
            return 1;
        end
        return 0;
    endfunction

    function automatic logic [XLEN-1:0] pc_of(input logic [XLEN-1:0] v,
                                               input logic irq, input int cause);
        logic [XLEN-1:0] b;
        b = v & ~64'd3;
        if (irq && v[1:0] == 2'd1) return b + 64'(cause) * 64'd4;
        return b;
    endfunction

    // one clock: drive at negedge, compare mid-cycle, advance model at posedge
    task automatic step(input string req, input logic rq, input logic [11:0] a,
                        input logic [1:0] op, input logic [XLEN-1:0] wd,
                        input logic [1:0] p, input logic v,
                        input logic irq, input int cause);
        int k;
        logic [XLEN-1:0] m;
        @(negedge clk);
        csr_req_i = rq; csr_addr_i = a; csr_op_i = op; csr_wdata_i = wd;
        csr_priv_i = p; csr_virt_i = v; trap_irq_i = irq;
        trap_cause_i = CAUSE_W'(cause);
        #1;
        k = route_of(rq, a, p, v);
        chk(req, "guest flag", 64'(csr_guest_o), 64'(k == 1));
        chk(req, "host flag", 64'(csr_host_o), 64'(k == 2));
        chk(req, "illegal flag", 64'(csr_illegal_o), 64'(k == 3));
        chk(req, "vfault flag", 64'(csr_vfault_o), 64'(k == 4));
        chk(req, "read data", csr_rdata_o, (k == 1) ? model : 64'd0);
        chk(req, "trap pc", trap_pc_o, pc_of(model, irq, cause));
        if (k == 1 && op != 2'd0) begin
            case (op)
                2'd1: m = wd;
                2'd2: m = model | wd;
                default: m = model & ~wd;
            endcase
            if (m[1]) m[1:0] = model[1:0];
            model = m;
        end
        @(posedge clk);
    endtask

    task automatic rd205(input string req);
        step(req, 1'b1, 12'h205, 2'd0, '0, 2'd1, 1'b0, 1'b0, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1 rst_ni = 1'b1;
        // R1: reset state
        rd205("R1");
        chk("R1", "reset read", csr_rdata_o, 64'd0);
        step("R1", 1'b0, 12'h0, 2'd0, '0, 2'd1, 1'b0, 1'b1, 5);
        // R2: host-side access at supervisor and machine
        step("R2", 1'b1, 12'h205, 2'd1, 64'h0000_0000_8000_1001, 2'd1, 1'b0, 1'b0, 0);
        rd205("R2");
        step("R2", 1'b1, 12'h205, 2'd1, 64'h0000_0040_0000_2000, 2'd3, 1'b0, 1'b0, 0);
        rd205("R2");
        // R3: user privilege
        step("R3", 1'b1, 12'h205, 2'd1, 64'hFFFF_0000_0000_0001, 2'd0, 1'b0, 1'b0, 0);
        rd205("R3");
        // R4: direct guest address while virtualized
        step("R4", 1'b1, 12'h205, 2'd1, 64'h1234_5678_0000_0001, 2'd1, 1'b1, 1'b0, 0);
        step("R4", 1'b1, 12'h205, 2'd2, 64'h1, 2'd0, 1'b1, 1'b0, 0);
        rd205("R4");
        // R5: alias through the supervisor address
        step("R5", 1'b1, 12'h105, 2'd1, 64'h0000_0000_0000_A001, 2'd1, 1'b1, 1'b0, 0);
        step("R5", 1'b1, 12'h105, 2'd0, '0, 2'd1, 1'b1, 1'b0, 0);
        rd205("R5");
        // R6: supervisor address, not virtualized
        step("R6", 1'b1, 12'h105, 2'd1, 64'hDEAD_0000_0000_0000, 2'd1, 1'b0, 1'b0, 0);
        rd205("R6");
        // R11: virtualized user on supervisor address
        step("R11", 1'b1, 12'h105, 2'd1, 64'h0, 2'd0, 1'b1, 1'b0, 0);
        rd205("R11");
        // R7: set and clear
        step("R7", 1'b1, 12'h205, 2'd2, 64'h0000_0000_00F0_0000, 2'd1, 1'b0, 1'b0, 0);
        rd205("R7");
        step("R7", 1'b1, 12'h205, 2'd3, 64'h0000_0000_0000_A001, 2'd1, 1'b0, 1'b0, 0);
        rd205("R7");
        // R8: reserved modes keep previous mode, base updates
        step("R8", 1'b1, 12'h205, 2'd1, 64'h0000_0000_0000_3001, 2'd1, 1'b0, 1'b0, 0);
        step("R8", 1'b1, 12'h205, 2'd1, 64'h0000_0000_0000_5002, 2'd1, 1'b0, 1'b0, 0);
        rd205("R8");
        chk("R8", "mode after rsvd 2", csr_rdata_o, 64'h0000_0000_0000_5001);
        step("R8", 1'b1, 12'h205, 2'd2, 64'h2, 2'd3, 1'b0, 1'b0, 0);
        rd205("R8");
        chk("R8", "set into rsvd 3", csr_rdata_o, 64'h0000_0000_0000_5001);
        // R10: vectored targets
        step("R10", 1'b0, 12'h0, 2'd0, '0, 2'd1, 1'b0, 1'b1, 0);
        step("R10", 1'b0, 12'h0, 2'd0, '0, 2'd1, 1'b0, 1'b1, 9);
        chk("R10", "irq 9 target", trap_pc_o, 64'h0000_0000_0000_5024);
        step("R10", 1'b0, 12'h0, 2'd0, '0, 2'd1, 1'b0, 1'b1, 63);
        step("R10", 1'b0, 12'h0, 2'd0, '0, 2'd1, 1'b0, 1'b0, 9);
        // R9: direct mode
        step("R9", 1'b1, 12'h205, 2'd1, 64'h0000_0000_0000_7000, 2'd1, 1'b0, 1'b0, 0);
        step("R9", 1'b0, 12'h0, 2'd0, '0, 2'd1, 1'b0, 1'b1, 9);
        chk("R9", "direct irq target", trap_pc_o, 64'h0000_0000_0000_7000);
        step("R9", 1'b0, 12'h0, 2'd0, '0, 2'd1, 1'b0, 1'b0, 3);
        // R12: other address and idle
        step("R12", 1'b1, 12'h305, 2'd1, 64'hFF, 2'd3, 1'b0, 1'b0, 0);
        step("R12", 1'b0, 12'h205, 2'd1, 64'hFF, 2'd1, 1'b0, 1'b0, 0);
        rd205("R12");
        // mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            logic [11:0] a;
            int sel;
            sel = int'($urandom_range(0, 2));
            a = (sel == 0) ? 12'h205 : (sel == 1) ? 12'h105 : 12'h305;
            step("R12", 1'($urandom_range(0, 1)), a, 2'($urandom_range(0, 3)),
                 {$urandom, $urandom}, 2'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 int'($urandom_range(0, 63)));
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule